// File: doc/BRIEF.md
# Multiprocessor-Format Serial Receiver with Wake-Up Filter

This block receives asynchronous serial characters on a multidrop line where every character carries one extra flag bit, the address marker, placed after the data bits. A marker of 1 tags the character as a station identifier and a marker of 0 tags it as ordinary payload. The line is sampled at sixteen times the bit rate, each bit is decided by a majority of three mid-bit samples, and the bits are assembled in a shift register. There is no parity bit in this frame format.

Host software owns a wake-up enable flag. It sets the flag with a one-cycle pulse once it has decided that the traffic on the line is not for its station. While the flag is set, payload characters are thrown away: the data register, the data-ready flag, the framing-error flag and the overrun flag are all left untouched. The first character that arrives with the marker set is accepted as a normal character. It is loaded and flagged, and it clears the wake-up flag. Software then compares the identifier with its own address and decides whether to listen or to set the flag again. The flag is captured when a start bit is detected, so a frame that is already under way finishes under the setting it started with.

The control path is a single state machine with five states. IDLE waits for a low line sample on an oversampling tick and goes to START. START goes back to IDLE if the voted start bit is high, and goes to DATA if it is low. DATA shifts 7 or 8 bits and goes to MPB after the last one. MPB stores the marker and goes to STOP. STOP checks one or two stop bits and, after the last one, delivers the character and goes back to IDLE.

Top module: `mpr_uart_rx`

## Requirements
- R1: After reset, rdy, ferr, oerr, mpb, wake_en and rx_irq are 0 and the line is taken as idle (high).
- R2: With cfg_len7=0, a frame consists of a low start bit, 8 data bits sent LSB first, a marker bit and then stop bits. It loads rx_data with the 8 data bits and sets rdy.
- R3: With cfg_len7=1, a frame carries 7 data bits. rx_data[6:0] holds them and rx_data[7] reads 0. The marker is the bit that follows the 7th data bit.
- R4: rd_ack clears rdy. When an accepted character completes while rdy is still 1, oerr is set and rx_data keeps the earlier character.
- R5: mpb takes the marker value of every character that is loaded, so a payload character reads back 0 and an identifier reads back 1.
- R6: A stop bit sampled low sets ferr. With cfg_two_stop=1 both stop bits are checked. The character is still loaded. err_clr clears ferr and oerr.
- R7: A wake_set pulse sets wake_en. A character whose marker is 0 and that started while wake_en was 1 changes none of rx_data, rdy, ferr or oerr, even if its stop bit is bad or rdy is still pending.
- R8: A character whose marker is 1 and that started while wake_en was 1 clears wake_en, is loaded, and sets rdy and mpb. Characters after it are received normally.
- R9: rx_irq is 1 exactly while rie and rdy are both 1. This includes the identifier character that ends a wake-up wait.
- R10: wake_en is sampled when a start bit is detected. A frame in progress when wake_set arrives is received normally and leaves wake_en set.
- R11: Each bit is decided by a majority of samples 7, 8 and 9 of its 16 oversampling ticks. A low pulse on the line that ends before mid-bit produces no character, and a single disturbed sample per bit does not change the received data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| os_tick | input | 1 | Oversampling enable, sixteen per bit time |
| rx_line | input | 1 | Serial receive line, idle high |
| cfg_len7 | input | 1 | 1 selects 7 data bits, 0 selects 8 |
| cfg_two_stop | input | 1 | 1 selects two stop bits |
| rie | input | 1 | Receive interrupt enable |
| wake_set | input | 1 | Pulse that sets the wake-up enable flag |
| rd_ack | input | 1 | Pulse that clears rdy after a read |
| err_clr | input | 1 | Pulse that clears ferr and oerr |
| rx_data | output | 8 | Receive data register |
| rdy | output | 1 | Data ready |
| ferr | output | 1 | Framing error |
| oerr | output | 1 | Overrun error |
| mpb | output | 1 | Marker bit of the last loaded character |
| wake_en | output | 1 | Wake-up enable flag |
| rx_irq | output | 1 | Receive interrupt |

## Verification
The 8-bit mode is swept over all 256 payload values with the marker at 0. This shows up any bit-order or shift-length fault and also checks that mpb reads back 0. The 7-bit mode is swept over all 128 values with the marker taken from the data. This separates the marker position from the data bits in both polarities. The wake-up filter gets a payload character with a bad stop bit while an earlier character is still pending, so that a leak into any of the four outputs can be seen. It is then released by an identifier with the interrupt enabled, and the wake_set pulse is also placed in the middle of a frame to test the start-time capture. Runs of short low glitches and of single disturbed samples separate the majority vote from a single-sample decision.

// File: rtl/mpr_rx_pkg.sv
package mpr_rx_pkg;

    localparam int DATA_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_MPB,
        ST_STOP
    } rx_state_e;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              mpb;
        logic              ferr;
        logic              wake;
    } rx_char_t;

endpackage

// File: rtl/mpr_rx_sync.sv
module mpr_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[0] <= 1'b1;
                else        chain[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[g] <= 1'b1;
                else        chain[g] <= chain[g-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/mpr_rx_frame.sv
module mpr_rx_frame
    import mpr_rx_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     os_tick,
    input  logic     rxs,
    input  logic     len7,
    input  logic     two_stop,
    input  logic     wake_en,
    output logic     chr_done,
    output rx_char_t chr
);
    localparam int CW = $clog2(OSR);
    localparam int BW = $clog2(DATA_W);
    localparam logic [CW-1:0] C_V0  = CW'(OSR/2 - 1);
    localparam logic [CW-1:0] C_V2  = CW'(OSR/2 + 1);
    localparam logic [CW-1:0] C_END = CW'(OSR - 1);
    localparam logic [BW-1:0] LAST8 = BW'(DATA_W - 1);
    localparam logic [BW-1:0] LAST7 = BW'(DATA_W - 2);

    rx_state_e st, st_nx;

    logic [CW-1:0]     cnt;
    logic [2:0]        samp;
    logic [BW-1:0]     bidx;
    logic              sidx;
    logic [DATA_W-1:0] sh;
    logic              ferr_acc;
    logic              mpb_q;
    logic              wake_q;

    logic bit_end;
    logic vote;
    logic last_data;
    logic last_stop;

    assign bit_end   = os_tick && (cnt == C_END);
    assign vote      = (samp[0] & samp[1]) | (samp[0] & samp[2]) | (samp[1] & samp[2]);
    assign last_data = (bidx == (len7 ? LAST7 : LAST8));
    assign last_stop = (sidx == two_stop);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // transitions
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE:  if (os_tick && !rxs)          st_nx = ST_START;
            ST_START: if (bit_end)                  st_nx = vote ? ST_IDLE : ST_DATA;
            ST_DATA:  if (bit_end && last_data)     st_nx = ST_MPB;
            ST_MPB:   if (bit_end)                  st_nx = ST_STOP;
            ST_STOP:  if (bit_end && last_stop)     st_nx = ST_IDLE;
            default:                                st_nx = ST_IDLE;
        endcase
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt      <= '0;
            samp     <= '1;
            bidx     <= '0;
            sidx     <= 1'b0;
            sh       <= '0;
            ferr_acc <= 1'b0;
            mpb_q    <= 1'b0;
            wake_q   <= 1'b0;
            chr_done <= 1'b0;
            chr      <= '0;
        end else begin
            chr_done <= 1'b0;
            if (os_tick) begin
                if (st == ST_IDLE) begin
                    if (!rxs) begin
                        cnt      <= CW'(1);
                        samp     <= '1;
                        bidx     <= '0;
                        sidx     <= 1'b0;
                        ferr_acc <= 1'b0;
                        wake_q   <= wake_en;
                    end
                end else begin
                    cnt <= bit_end ? '0 : cnt + 1'b1;
                    if (cnt >= C_V0 && cnt <= C_V2) begin
                        samp <= {samp[1:0], rxs};
                    end
                    if (bit_end) begin
                        case (st)
                            ST_DATA: begin
                                sh   <= {vote, sh[DATA_W-1:1]};
                                bidx <= bidx + 1'b1;
                            end
                            ST_MPB: begin
                                mpb_q <= vote;
                            end
                            ST_STOP: begin
                                ferr_acc <= ferr_acc | ~vote;
                                sidx     <= 1'b1;
                                if (last_stop) begin
                                    chr_done  <= 1'b1;
                                    chr.data  <= len7 ? {1'b0, sh[DATA_W-1:1]} : sh;
                                    chr.mpb   <= mpb_q;
                                    chr.ferr  <= ferr_acc | ~vote;
                                    chr.wake  <= wake_q;
                                end
                            end
                            default: ;
                        endcase
                    end
                end
            end
        end
    end
endmodule

// File: rtl/mpr_rx_status.sv
module mpr_rx_status
    import mpr_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chr_done,
    input  rx_char_t          chr,
    input  logic              rd_ack,
    input  logic              err_clr,
    input  logic              wake_set,
    output logic [DATA_W-1:0] rx_data,
    output logic              rdy,
    output logic              ferr,
    output logic              oerr,
    output logic              mpb,
    output logic              wake_en
);
    logic accept;
    logic pending;

    assign accept  = !chr.wake || chr.mpb;
    assign pending = rdy && !rd_ack;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_data <= '0;
            rdy     <= 1'b0;
            ferr    <= 1'b0;
            oerr    <= 1'b0;
            mpb     <= 1'b0;
            wake_en <= 1'b0;
        end else begin
            if (rd_ack)   rdy <= 1'b0;
            if (err_clr) begin
                ferr <= 1'b0;
                oerr <= 1'b0;
            end
            if (wake_set) wake_en <= 1'b1;
            if (chr_done) begin
                if (chr.wake && chr.mpb && !wake_set) wake_en <= 1'b0;
                if (accept) begin
                    if (pending) begin
                        oerr <= 1'b1;
                    end else begin
                        rx_data <= chr.data;
                        rdy     <= 1'b1;
                        mpb     <= chr.mpb;
                        if (chr.ferr) ferr <= 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/mpr_uart_rx.sv
module mpr_uart_rx
    import mpr_rx_pkg::*;
#(
    parameter int OSR         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       os_tick,
    input  logic       rx_line,
    input  logic       cfg_len7,
    input  logic       cfg_two_stop,
    input  logic       rie,
    input  logic       wake_set,
    input  logic       rd_ack,
    input  logic       err_clr,
    output logic [7:0] rx_data,
    output logic       rdy,
    output logic       ferr,
    output logic       oerr,
    output logic       mpb,
    output logic       wake_en,
    output logic       rx_irq
);
    logic     rxs;
    logic     chr_done;
    rx_char_t chr;

    mpr_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (rx_line),
        .q     (rxs)
    );

    mpr_rx_frame #(.OSR(OSR)) u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .os_tick  (os_tick),
        .rxs      (rxs),
        .len7     (cfg_len7),
        .two_stop (cfg_two_stop),
        .wake_en  (wake_en),
        .chr_done (chr_done),
        .chr      (chr)
    );

    mpr_rx_status u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .chr_done (chr_done),
        .chr      (chr),
        .rd_ack   (rd_ack),
        .err_clr  (err_clr),
        .wake_set (wake_set),
        .rx_data  (rx_data),
        .rdy      (rdy),
        .ferr     (ferr),
        .oerr     (oerr),
        .mpb      (mpb),
        .wake_en  (wake_en)
    );

    assign rx_irq = rie & rdy;
endmodule

// File: rtl/mpr_uart_rx_chk.sv
module mpr_uart_rx_chk
    import mpr_rx_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       wake_set,
    input logic       rd_ack,
    input logic       err_clr,
    input logic [7:0] rx_data,
    input logic       rdy,
    input logic       ferr,
    input logic       oerr,
    input logic       mpb,
    input logic       wake_en,
    input logic       chr_done,
    input rx_char_t   chr
);
    p_ack_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ack && !chr_done |=> !rdy);

    p_rdy_from_char_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rdy) |-> $past(chr_done));

    p_overrun_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
        chr_done && (!chr.wake || chr.mpb) && rdy && !rd_ack
        |=> oerr && $stable(rx_data));

    p_wake_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        chr_done && chr.wake && !chr.mpb && !rd_ack && !err_clr
        |=> $stable(rdy) && $stable(rx_data) && $stable(ferr) && $stable(oerr));

    p_wake_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        chr_done && chr.wake && chr.mpb && !wake_set && (!rdy || rd_ack)
        |=> !wake_en && mpb && rdy);

    p_wake_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_en) |-> $past(wake_set));
endmodule

bind mpr_uart_rx mpr_uart_rx_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wake_set (wake_set),
    .rd_ack   (rd_ack),
    .err_clr  (err_clr),
    .rx_data  (rx_data),
    .rdy      (rdy),
    .ferr     (ferr),
    .oerr     (oerr),
    .mpb      (mpb),
    .wake_en  (wake_en),
    .chr_done (chr_done),
    .chr      (chr)
);

// File: tb/mpr_uart_rx_bench.sv
module mpr_uart_rx_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       os_tick = 1'b1;
    logic       rx_line = 1'b1;
    logic       cfg_len7 = 1'b0;
    logic       cfg_two_stop = 1'b0;
    logic       rie = 1'b0;
    logic       wake_set = 1'b0;
    logic       rd_ack = 1'b0;
    logic       err_clr = 1'b0;
    logic [7:0] rx_data;
    logic       rdy, ferr, oerr, mpb, wake_en, rx_irq;

    int n_chk  = 0;
    int n_fail = 0;
    logic [7:0] last_val;

    always #10 clk = ~clk;

    mpr_uart_rx u_mpr_uart_rx (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rx_line(rx_line),
        .cfg_len7(cfg_len7), .cfg_two_stop(cfg_two_stop), .rie(rie),
        .wake_set(wake_set), .rd_ack(rd_ack), .err_clr(err_clr),
        .rx_data(rx_data), .rdy(rdy), .ferr(ferr), .oerr(oerr),
        .mpb(mpb), .wake_en(wake_en), .rx_irq(rx_irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hold(input logic v, input logic noisy, input logic pulse_wake);
        for (int i = 0; i < 16; i++) begin
            rx_line  = (noisy && i == 8) ? ~v : v;
            wake_set = pulse_wake && (i == 0);
            @(negedge clk);
        end
        wake_set = 1'b0;
    endtask

    task automatic send(input logic [7:0] d, input logic mb, input int nb, input int ns,
                        input logic bad_stop, input logic noisy, input logic mid_wake);
        hold(1'b0, noisy, 1'b0);
        for (int b = 0; b < nb; b++) hold(d[b], noisy, mid_wake && b == 2);
        hold(mb, noisy, 1'b0);
        for (int s = 0; s < ns; s++) hold(!(bad_stop && s == ns - 1), 1'b0, 1'b0);
        rx_line = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic pulse_ack();
        rd_ack = 1'b1; @(negedge clk); rd_ack = 1'b0; @(negedge clk);
    endtask

    task automatic pulse_clr();
        err_clr = 1'b1; @(negedge clk); err_clr = 1'b0; @(negedge clk);
    endtask

    task automatic pulse_wake();
        wake_set = 1'b1; @(negedge clk); wake_set = 1'b0; @(negedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R1 watchdog actual=%0d expected=%0d", 200000, 0);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 rdy", rdy, 0);
        check("R1 ferr", ferr, 0);
        check("R1 oerr", oerr, 0);
        check("R1 mpb", mpb, 0);
        check("R1 wake_en", wake_en, 0);
        check("R1 rx_irq", rx_irq, 0);

        // R2 / R5: 8-bit sweep with marker 0
        for (int v = 0; v < 256; v++) begin
            send(8'(v), 1'b0, 8, 1, 1'b0, 1'b0, 1'b0);
            check("R2 data", rx_data, v);
            check("R2 rdy", rdy, 1);
            check("R5 mpb payload", mpb, 0);
            check("R6 ferr clean", ferr, 0);
            pulse_ack();
            check("R4 ack", rdy, 0);
        end

        // R3 / R5: 7-bit sweep, marker derived from data
        cfg_len7 = 1'b1;
        for (int v = 0; v < 128; v++) begin
            logic mb;
            mb = v[0] ^ v[3];
            send(8'(v), mb, 7, 1, 1'b0, 1'b0, 1'b0);
            check("R3 data7", rx_data, v);
            check("R5 mpb7", mpb, mb);
            pulse_ack();
        end
        cfg_len7 = 1'b0;

        // R4 overrun
        send(8'hA5, 1'b0, 8, 1, 1'b0, 1'b0, 1'b0);
        send(8'h3C, 1'b0, 8, 1, 1'b0, 1'b0, 1'b0);
        check("R4 overrun keep", rx_data, 8'hA5);
        check("R4 oerr", oerr, 1);
        pulse_clr();
        check("R6 clr oerr", oerr, 0);
        pulse_ack();

        // R6 framing
        send(8'h5A, 1'b0, 8, 1, 1'b1, 1'b0, 1'b0);
        check("R6 ferr", ferr, 1);
        check("R6 data loaded", rx_data, 8'h5A);
        pulse_clr();
        check("R6 clr ferr", ferr, 0);
        pulse_ack();
        cfg_two_stop = 1'b1;
        send(8'h81, 1'b0, 8, 2, 1'b1, 1'b0, 1'b0);
        check("R6 second stop", ferr, 1);
        pulse_clr();
        pulse_ack();
        send(8'h7E, 1'b1, 8, 2, 1'b0, 1'b0, 1'b0);
        check("R6 two stop ok", ferr, 0);
        check("R6 two stop data", rx_data, 8'h7E);
        check("R5 mpb id", mpb, 1);
        pulse_ack();
        cfg_two_stop = 1'b0;

        // R9 interrupt
        rie = 1'b1;
        send(8'h42, 1'b0, 8, 1, 1'b0, 1'b0, 1'b0);
        check("R9 irq on", rx_irq, 1);
        pulse_ack();
        check("R9 irq off", rx_irq, 0);
        last_val = 8'h42;

        // R7: filter while a character is still pending
        send(8'h11, 1'b0, 8, 1, 1'b0, 1'b0, 1'b0);
        last_val = 8'h11;
        pulse_wake();
        check("R7 wake set", wake_en, 1);
        send(8'hEE, 1'b0, 8, 1, 1'b1, 1'b0, 1'b0);
        check("R7 no oerr", oerr, 0);
        check("R7 no ferr", ferr, 0);
        check("R7 data kept", rx_data, last_val);
        check("R7 still waiting", wake_en, 1);
        pulse_ack();
        send(8'h99, 1'b0, 8, 1, 1'b0, 1'b0, 1'b0);
        check("R7 no rdy", rdy, 0);
        check("R7 data kept2", rx_data, last_val);

        // R8 / R9: identifier releases the filter
        send(8'h2D, 1'b1, 8, 1, 1'b0, 1'b0, 1'b0);
        check("R8 wake cleared", wake_en, 0);
        check("R8 id data", rx_data, 8'h2D);
        check("R8 mpb", mpb, 1);
        check("R9 irq id", rx_irq, 1);
        pulse_ack();
        send(8'h64, 1'b0, 8, 1, 1'b0, 1'b0, 1'b0);
        check("R8 resumed", rx_data, 8'h64);
        check("R8 resumed rdy", rdy, 1);
        pulse_ack();
        rie = 1'b0;

        // R10: wake_set in the middle of a frame
        send(8'hC3, 1'b0, 8, 1, 1'b0, 1'b0, 1'b1);
        check("R10 frame kept", rx_data, 8'hC3);
        check("R10 rdy", rdy, 1);
        check("R10 wake", wake_en, 1);
        pulse_ack();
        send(8'h3E, 1'b0, 8, 1, 1'b0, 1'b0, 1'b0);
        check("R10 next dropped", rdy, 0);
        send(8'h01, 1'b1, 8, 1, 1'b0, 1'b0, 1'b0);
        check("R10 released", wake_en, 0);
        pulse_ack();

        // R11: short glitches and single disturbed samples
        for (int g = 1; g <= 6; g++) begin
            rx_line = 1'b0;
            repeat (g) @(negedge clk);
            rx_line = 1'b1;
            repeat (40) @(negedge clk);
            check("R11 glitch", rdy, 0);
        end
        for (int v = 0; v < 256; v += 37) begin
            send(8'(v), v[1], 8, 1, 1'b0, 1'b1, 1'b0);
            check("R11 noisy data", rx_data, v);
            check("R11 noisy mpb", mpb, v[1]);
            pulse_ack();
        end

        finish_run();
    end
endmodule